// File: doc/BRIEF.md
# Serial Peripheral Slave with Gapless Word Streaming

This block is the target side of a four-wire serial peripheral link. The bus clock, select and data input come from an external master. The block shifts words of `WORD_W` bits in and out, most significant bit first. Every bus input is brought into the system clock domain through a register chain. Edges of the bus clock are then found by comparing successive synchronised samples, so the whole block runs on the one fast system clock. The clock polarity and phase inputs pick one of the four bus modes. From them, one edge of each bus clock period becomes the capture edge and the other becomes the drive edge.

On the user side, a one-cycle request pulse marks each moment the slave takes a new transmit word from its holding register. The user answers by writing the next word. A completed receive word comes out with a one-cycle valid strobe. While select stays low and the master keeps clocking, the bit position runs from 1 to `WORD_W` and wraps with no idle gap. If the user ignores a request, the holding register still holds the previous word, and that word goes out again.

The controller has three states:
- `ST_IDLE`: select is inactive. The bit position and shift registers are cleared and MISO is held low.
- `ST_ARM`: a single cycle after select becomes active. In phase-0 modes the first word is loaded here.
- `ST_RUN`: bus edges are processed.

The transitions are:
- IDLE→ARM when select becomes active.
- ARM→RUN while select stays active.
- ARM→IDLE or RUN→IDLE when select is released.

Top module: `spis_top`

## Requirements
- R1: After synchronous reset `spi_miso`, `tx_req` and `rx_valid` are 0, and the transmit holding register is 0, so a word sent before any write is all zeros.
- R2: With `cpol`=0 the leading edge is rising, and with `cpol`=1 it is falling. With `cpha`=0 data is captured on the leading edge and driven on the trailing edge. With `cpha`=1 it is the other way round. All four modes transfer correctly.
- R3: MOSI is captured on each capture edge, most significant bit first. After the `WORD_W`-th capture, `rx_data` holds the word and `rx_valid` is high.
- R4: MISO presents the loaded word most significant bit first and changes only on drive edges. In phase-0 modes the first bit is presented before the first clock edge.
- R5: `tx_req` pulses for one system clock each time a word is loaded from the holding register. In phase-0 modes this happens at select assertion and at the drive edge after each word's last bit. In phase-1 modes it happens at the first drive edge of each word.
- R6: While select stays low, consecutive words stream back to back with no idle bus clocks, and the bit position wraps from `WORD_W` to 1 without any user action.
- R7: If no word is written after a request, the next word transmitted repeats the holding register's current content, that is, the last word written.
- R8: Releasing select clears the bit position and discards a partial word without a `rx_valid`. MISO reads 0 while select is released.
- R9: `rx_valid` is high for exactly one system clock per completed word.
- R10: A write (`wr_en`=1) replaces the holding register. The value is kept until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpol | input | 1 | Bus clock idle level; hold stable while selected |
| cpha | input | 1 | Capture on trailing edge when 1; hold stable while selected |
| spi_sck | input | 1 | Bus clock from master |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | WORD_W | Next transmit word |
| tx_req | output | 1 | One-cycle request for the next transmit word |
| rx_data | output | WORD_W | Last completed receive word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The bench builds the block with `WORD_W`=8 and `SYNC_STAGES`=2, and drives the bus clock with a half period of eight system clocks. At that rate every synchroniser and edge-detector delay fits inside a half period. This lets the bench master sample MISO at its own edges, as a real master would. The eight-bit word makes multi-word streams short, so all four modes, ignored requests, an aborted half word and the first word after reset each fit in one run. A behavioural model of the holding register records the expected transmit word at every request pulse. The monitor also checks the idle MISO level and the pulse widths on every clock.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } spis_state_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spis_edges.sv
module spis_edges (
    input  logic clk,
    input  logic rst,
    input  logic sck_s,
    input  logic cpol,
    input  logic cpha,
    output logic shift_en,
    output logic change_en
);
    logic sck_p;
    logic rise, fall, lead, trail;

    always_ff @(posedge clk) begin
        if (rst) sck_p <= sck_s;
        else     sck_p <= sck_s;
    end

    always_comb begin
        rise      = sck_s & ~sck_p;
        fall      = ~sck_s & sck_p;
        lead      = cpol ? fall : rise;
        trail     = cpol ? rise : fall;
        shift_en  = cpha ? trail : lead;
        change_en = cpha ? lead : trail;
    end
endmodule

// File: rtl/spis_ctrl.sv
module spis_ctrl
    import spis_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_act,
    output logic clr,
    output logic arm,
    output logic run
);
    spis_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE: begin
                nxt = cs_act ? ST_ARM : ST_IDLE;
                clr = 1'b1;
                arm = 1'b0;
                run = 1'b0;
            end
            ST_ARM: begin
                nxt = cs_act ? ST_RUN : ST_IDLE;
                clr = 1'b0;
                arm = 1'b1;
                run = 1'b0;
            end
            ST_RUN: begin
                nxt = cs_act ? ST_RUN : ST_IDLE;
                clr = 1'b0;
                arm = 1'b0;
                run = 1'b1;
            end
            default: begin
                nxt = ST_IDLE;
                clr = 1'b1;
                arm = 1'b0;
                run = 1'b0;
            end
        endcase
    end

    // R8: arming lasts one cycle per select assertion
    p_arm_single_r8: assert property (@(posedge clk) disable iff (rst)
        arm |=> !arm);
endmodule

// File: rtl/spis_datapath.sv
module spis_datapath #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              arm,
    input  logic              run,
    input  logic              cpha,
    input  logic              shift_en,
    input  logic              change_en,
    input  logic              mosi_s,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              miso,
    output logic              tx_req,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    localparam int CW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST_IDX = CW'(WORD_W - 1);

    logic [WORD_W-1:0] hold_q, tx_sr, rx_sr;
    logic [CW-1:0]     bit_cnt;
    logic              load_now, shift_now, samp, last;

    always_comb begin
        load_now  = (arm && !cpha) || (run && change_en && bit_cnt == '0);
        shift_now = run && change_en && bit_cnt != '0;
        samp      = run && shift_en;
        last      = samp && bit_cnt == LAST_IDX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            bit_cnt <= '0;
        end else begin
            if (load_now)       tx_sr <= hold_q;
            else if (shift_now) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            if (samp) begin
                rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s};
                bit_cnt <= last ? '0 : bit_cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_req   <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            tx_req   <= load_now && !clr;
            rx_valid <= last && !clr;
            if (last && !clr) rx_data <= {rx_sr[WORD_W-2:0], mosi_s};
        end
    end

    assign miso = tx_sr[WORD_W-1];

    p_req_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        tx_req |=> !tx_req);
    p_req_cause_r5: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> $past(arm || change_en));
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    p_valid_cause_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(run && shift_en));
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= LAST_IDX);
endmodule

// File: rtl/spis_top.sv
module spis_top #(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_req,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid
);
    logic [2:0] bus_s;
    logic       cs_act, shift_en, change_en, clr, arm, run;

    spis_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_mosi}),
        .q   (bus_s)
    );

    assign cs_act = !bus_s[2];

    spis_edges u_edges (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (bus_s[1]),
        .cpol      (cpol),
        .cpha      (cpha),
        .shift_en  (shift_en),
        .change_en (change_en)
    );

    spis_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cs_act (cs_act),
        .clr    (clr),
        .arm    (arm),
        .run    (run)
    );

    spis_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .arm       (arm),
        .run       (run),
        .cpha      (cpha),
        .shift_en  (shift_en),
        .change_en (change_en),
        .mosi_s    (bus_s[0]),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .miso      (spi_miso),
        .tx_req    (tx_req),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    // R8: MISO quiet once the controller has been idle for a cycle
    p_idle_miso_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && $past(clr)) |-> !spi_miso);
endmodule

// File: tb/spis_top_tb_top.sv
module spis_top_tb_top;
    localparam int W = 8;
    localparam int H = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpol_r = 1'b0, cpha_r = 1'b0;
    logic         sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         miso, tx_req, rx_valid;
    logic [W-1:0] rx_data;

    always #10 clk = ~clk;

    spis_top #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cpol(cpol_r), .cpha(cpha_r),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
        .wr_en(wr_en), .wr_data(wr_data), .tx_req(tx_req),
        .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int checks = 0, fails = 0;
    int req_cnt = 0, rxv_cnt = 0, req_wide = 0, rxv_wide = 0, idle_cnt = 0;
    bit respond = 0, pend = 0, force_wr = 0, prev_req = 0, prev_rxv = 0, done = 0;
    logic [W-1:0] model_hold = '0;
    logic [W-1:0] user_q[$], exp_tx[$], got_rx[$], got_miso[$], sent[$];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // behavioural user side and monitor, every clock
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                wr_en = 1'b0;
                if ((pend || force_wr) && user_q.size() > 0) begin
                    wr_data    = user_q.pop_front();
                    wr_en      = 1'b1;
                    model_hold = wr_data;   // R10 model
                    pend       = 0;
                    force_wr   = 0;
                end
                if (tx_req) begin
                    req_cnt++;
                    exp_tx.push_back(model_hold);
                    if (prev_req) req_wide++;
                    if (respond) pend = 1;
                end
                if (rx_valid) begin
                    rxv_cnt++;
                    got_rx.push_back(rx_data);
                    if (prev_rxv) rxv_wide++;
                end
                if (cs_n) idle_cnt++; else idle_cnt = 0;
                if (idle_cnt >= 6)
                    check(miso == 1'b0, "R8", "idle miso", int'(miso), 0);
                prev_req = tx_req;
                prev_rxv = rx_valid;
            end
        end
    end

    task automatic xfer(input bit pol, input bit pha, input int nw);
        logic [W-1:0] rcv;
        cpol_r = pol; cpha_r = pha; sck = pol;
        tick(6);
        cs_n = 1'b0;
        tick(10);
        for (int w = 0; w < nw; w++) begin
            for (int b = W - 1; b >= 0; b--) begin
                if (!pha) begin
                    mosi = sent[w][b];
                    tick(H); sck = ~pol; rcv[b] = miso;
                    tick(H); sck = pol;
                end else begin
                    tick(H); sck = ~pol; mosi = sent[w][b];
                    tick(H); sck = pol; rcv[b] = miso;
                end
            end
            got_miso.push_back(rcv);
        end
        tick(H);
        cs_n = 1'b1;
        tick(12);
    endtask

    task automatic run_case(input bit pol, input bit pha, input int nw,
                            input bit resp, input int seed);
        int r0, v0;
        exp_tx.delete(); got_rx.delete(); got_miso.delete(); sent.delete();
        respond = resp;
        r0 = req_cnt; v0 = rxv_cnt;
        for (int i = 0; i < nw; i++) sent.push_back(W'(seed * 37 + i * 91 + 5));
        xfer(pol, pha, nw);
        check(rxv_cnt - v0 == nw, "R9", "valid count", rxv_cnt - v0, nw);
        check(req_cnt - r0 == nw + (pha ? 0 : 1), "R5", "request count",
              req_cnt - r0, nw + (pha ? 0 : 1));
        for (int i = 0; i < nw; i++) begin
            // R2 R3 R6: every mode, every streamed word
            if (i < got_rx.size())
                check(got_rx[i] == sent[i], "R3", "rx word", got_rx[i], sent[i]);
            else
                check(0, "R6", "rx word missing", 0, sent[i]);
            if (i < exp_tx.size())
                check(got_miso[i] == exp_tx[i], "R4", "miso word", got_miso[i], exp_tx[i]);
            else
                check(0, "R5", "request missing", 0, 1);
        end
    endtask

    task automatic user_write(input logic [W-1:0] v);
        user_q.push_back(v);
        force_wr = 1;
        tick(4);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        check(miso == 0, "R1", "reset miso", int'(miso), 0);
        check(tx_req == 0, "R1", "reset tx_req", int'(tx_req), 0);
        check(rx_valid == 0, "R1", "reset rx_valid", int'(rx_valid), 0);

        // R1: first word after reset with no write is zero
        run_case(0, 0, 1, 0, 1);
        check(got_miso.size() > 0 && got_miso[0] == 0, "R1", "first word",
              got_miso.size() > 0 ? got_miso[0] : -1, 0);

        // R2 R6: all four modes, four gapless words, user answers requests
        for (int m = 0; m < 4; m++) begin
            user_q.delete();
            user_write(W'(8'hA5 ^ m));
            for (int k = 0; k < 5; k++) user_q.push_back(W'(8'h30 + m * 16 + k));
            run_case(m[1], m[0], 4, 1, m + 2);
        end

        // R7 R10: requests ignored, held word resent
        user_q.delete();
        user_write(8'h5A);
        run_case(0, 0, 3, 0, 9);
        for (int i = 0; i < 3; i++)
            check(got_miso[i] == 8'h5A, "R7", "repeat mode0", got_miso[i], 8'h5A);
        run_case(1, 1, 3, 0, 10);
        for (int i = 0; i < 3; i++)
            check(got_miso[i] == 8'h5A, "R7", "repeat mode3", got_miso[i], 8'h5A);

        // R8: abort after three bits, then a clean transfer
        begin
            int v0;
            v0 = rxv_cnt;
            respond = 0;
            cpol_r = 0; cpha_r = 0; sck = 0;
            tick(6); cs_n = 1'b0; tick(10);
            for (int b = 0; b < 3; b++) begin
                mosi = 1'b1; tick(H); sck = 1; tick(H); sck = 0;
            end
            tick(H); cs_n = 1'b1; tick(14);
            check(rxv_cnt == v0, "R8", "no valid on abort", rxv_cnt - v0, 0);
        end
        user_q.delete();
        user_write(8'hC3);
        user_q.push_back(8'h3C); user_q.push_back(8'h99);
        run_case(0, 0, 2, 1, 11);

        check(req_wide == 0, "R5", "tx_req width", req_wide, 0);
        check(rxv_wide == 0, "R9", "rx_valid width", rxv_wide, 0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule